// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder (Ladner-Fischer tree, generate-only final level)

This block adds two unsigned operands of `WIDTH` bits and a single carry-in bit, giving a `WIDTH`-bit sum and a carry-out. The width defaults to 16 and must be a power of two of at least 4. The carry network is a parallel-prefix tree of the Ladner-Fischer kind. Each bit first forms a local propagate (XOR of the operand bits) and a local generate (AND of the operand bits). The tree then gives every bit the group generate over all bits below it. Finally each sum bit is its propagate XORed with the carry from the bit below.

The carry-in acts as the generate of an imaginary bit below bit 0. It is merged into bit 0 before the tree starts, so every group that reaches bit 0 already includes it. The tree works in two parts. The odd bit positions are resolved first: neighbouring pairs are joined, then spans that double at each level. One extra level then fills in the even positions. A combining node that still needs its group propagate for a later node carries both generate and propagate. Every other node, including all of the even fill-in level, computes the generate term only.

The sum and carry-out are captured in registers with a synchronous active-high reset. A result is therefore visible one clock edge after its operands are applied. The adder itself is purely combinational between the input ports and those registers.

Top module: `lf_adder`

## Requirements
- R1: On every rising clock edge with `rst` high, `sum` and `cout` become all zero, whatever the operands and carry-in are.
- R2: After a rising edge with `rst` low, `{cout, sum}` equals the (WIDTH+1)-bit unsigned value a + b + cin of the operands present at that edge, including 0 + 0 + 0 = 0.
- R3: A carry-in of 1 adds exactly one: with a all ones, b zero and cin 1, the next `sum` is zero and `cout` is 1.
- R4: The largest input, a and b all ones with cin 1, gives `sum` all ones and `cout` 1.
- R5: `cout` is 1 exactly when a + b + cin is at least 2^WIDTH. For example, 0xAAAA + 0x5555 gives 0xFFFF with `cout` 0 when cin is 0, and gives 0x0000 with `cout` 1 when cin is 1.
- R6: The carry into every bit position is correct for carry chains of every length. With a = 2^i - 1 and b = 1, the sum is 2^i for each i in 1..WIDTH, where i = WIDTH shows as `sum` zero and `cout` 1. With a = b = 2^i, the sum is 2^(i+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Registered sum, low WIDTH bits of a + b + cin |
| cout | output | 1 | Registered carry-out, bit WIDTH of a + b + cin |

## Verification
A wrong node in the prefix tree gives a wrong carry into one or more bit positions. The matching sum bits flip, or `cout` flips if the top group is wrong, on the very next clock edge after an operand pair that uses that node. Patterns that only exercise short carries can hide such a fault. The bench therefore drives carry chains of every length and adds of single bits at every position, so that each tree node decides some result bit. It also drives random operands and the all-ones and alternating corner values.

// File: rtl/lf_pkg.sv
package lf_pkg;
  // Pair-index partner of pair j at doubling level s: last pair of the block below.
  function automatic int pair_partner(int j, int s);
    return ((j >> s) << s) - 1;
  endfunction

  // After combining at level s, pair j's group reaches down to bit 0.
  function automatic bit span_from_root(int j, int s);
    return j < (1 << (s + 1));
  endfunction
endpackage

// File: rtl/lf_cell_gray.sv
module lf_cell_gray (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  output logic g_out
);
  assign g_out = g_hi | (p_hi & g_lo);
endmodule

// File: rtl/lf_cell_black.sv
module lf_cell_black (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);
  assign g_out = g_hi | (p_hi & g_lo);
  assign p_out = p_hi & p_lo;
endmodule

// File: rtl/lf_tree.sv
module lf_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] p,
  input  logic [WIDTH-1:0] g,
  input  logic             cin,
  output logic [WIDTH-1:0] gfull
);
  import lf_pkg::*;

  localparam int LOGW  = $clog2(WIDTH);
  localparam int PAIRS = WIDTH / 2;
  localparam int SKL   = LOGW - 1;
  localparam int LAST  = SKL + 1;

  logic gv [0:LAST][0:WIDTH-1];
  logic pv [0:LAST][0:WIDTH-1];

  // Level 0: local terms, with carry-in merged into bit 0.
  lf_cell_gray u_cin (.g_hi(g[0]), .p_hi(p[0]), .g_lo(cin), .g_out(gv[0][0]));
  assign pv[0][0] = 1'b0;
  for (genvar i = 1; i < WIDTH; i++) begin : g_l0
    assign gv[0][i] = g[i];
    assign pv[0][i] = p[i];
  end

  // Level 1: each odd bit joins its even neighbour.
  for (genvar i = 0; i < WIDTH; i++) begin : g_l1
    if (i % 2 == 0) begin : g_pass
      assign gv[1][i] = gv[0][i];
      assign pv[1][i] = pv[0][i];
    end else if (i == 1) begin : g_gray
      lf_cell_gray u_c (.g_hi(gv[0][i]), .p_hi(pv[0][i]), .g_lo(gv[0][i-1]),
                        .g_out(gv[1][i]));
      assign pv[1][i] = 1'b0;
    end else begin : g_black
      lf_cell_black u_c (.g_hi(gv[0][i]), .p_hi(pv[0][i]), .g_lo(gv[0][i-1]),
                         .p_lo(pv[0][i-1]), .g_out(gv[1][i]), .p_out(pv[1][i]));
    end
  end

  // Doubling levels over odd positions.
  for (genvar s = 0; s < SKL; s++) begin : g_lvl
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if ((i % 2 == 0) || (((i / 2) >> s) % 2 == 0)) begin : g_pass
        assign gv[s+2][i] = gv[s+1][i];
        assign pv[s+2][i] = pv[s+1][i];
      end else if (span_from_root(i / 2, s)) begin : g_gray
        lf_cell_gray u_c (.g_hi(gv[s+1][i]), .p_hi(pv[s+1][i]),
                          .g_lo(gv[s+1][2*pair_partner(i/2, s)+1]),
                          .g_out(gv[s+2][i]));
        assign pv[s+2][i] = 1'b0;
      end else begin : g_black
        lf_cell_black u_c (.g_hi(gv[s+1][i]), .p_hi(pv[s+1][i]),
                           .g_lo(gv[s+1][2*pair_partner(i/2, s)+1]),
                           .p_lo(pv[s+1][2*pair_partner(i/2, s)+1]),
                           .g_out(gv[s+2][i]), .p_out(pv[s+2][i]));
      end
    end
  end

  // Final level: even positions filled in, generate only.
  for (genvar i = 0; i < WIDTH; i++) begin : g_fin
    if ((i % 2 == 1) || (i == 0)) begin : g_take
      assign gfull[i] = gv[LAST][i];
    end else begin : g_gray
      lf_cell_gray u_c (.g_hi(g[i]), .p_hi(p[i]), .g_lo(gv[LAST][i-1]),
                        .g_out(gfull[i]));
    end
  end
endmodule

// File: rtl/lf_adder.sv
module lf_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] gfull;
  logic [WIDTH-1:0] carry_in;
  logic [WIDTH-1:0] sum_c;

  assign prop = a ^ b;
  assign gen  = a & b;

  lf_tree #(.WIDTH(WIDTH)) u_tree (
    .p(prop), .g(gen), .cin(cin), .gfull(gfull)
  );

  assign carry_in = {gfull[WIDTH-2:0], cin};
  assign sum_c    = prop ^ carry_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= gfull[WIDTH-1];
    end
  end

  logic [WIDTH:0] ref_full;
  assign ref_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum == '0 && !cout));

  // R2
  sum_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sum == $past(ref_full[WIDTH-1:0])));

  // R5
  cout_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cout == $past(ref_full[WIDTH])));

  // R3
  cin_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cin) && $past(a) == '1 && $past(b) == '0)
      |-> (sum == '0 && cout));

  // R6
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    carry_in == (prop ^ ref_full[WIDTH-1:0]));
endmodule

// File: tb/tb_lf_adder.sv
module tb_lf_adder;
  localparam int W = 16;

  typedef struct {
    logic [W:0] exp;
    string      tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int failures = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  lf_adder #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic ci, input string tag);
    item_t it;
    @(negedge clk);
    a = x; b = y; cin = ci;
    it.exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic check_zero(input string tag);
    checks++;
    if (sum !== '0 || cout !== 1'b0) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, {cout, sum}, {(W+1){1'b0}});
    end
  endtask

  // Monitor: compare each result one edge after its operands.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if ({cout, sum} !== it.exp) begin
          failures++;
          $display("FAIL %s got=%h exp=%h", it.tag, {cout, sum}, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R2 got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    a = 16'h1234; b = 16'h4321; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_zero("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    drive(16'h0000, 16'h0000, 1'b0, "R2 zero");
    drive(16'h1234, 16'h4321, 1'b0, "R2 plain");
    drive(16'hFFFF, 16'h0001, 1'b0, "R2 wrap");
    drive(16'hFFFF, 16'h0000, 1'b1, "R3 cin");
    drive(16'h7FFF, 16'h0000, 1'b1, "R3 cin mid");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R4 max");
    drive(16'hAAAA, 16'h5555, 1'b0, "R5 alt nocarry");
    drive(16'hAAAA, 16'h5555, 1'b1, "R5 alt carry");
    drive(16'hAAAA, 16'hAAAA, 1'b0, "R5 alt double");
    drive(16'h8000, 16'h7FFF, 1'b0, "R5 just below");
    drive(16'h8000, 16'h8000, 1'b0, "R5 top bits");

    for (int i = 1; i <= W; i++) begin
      logic [W:0] ones;
      ones = ({{W{1'b0}}, 1'b1} << i) - 1;
      drive(ones[W-1:0], 16'h0001, 1'b0, "R6 chain");
    end
    for (int i = 0; i < W; i++) begin
      drive(16'h0001 << i, 16'h0001 << i, 1'b0, "R6 single");
    end

    for (int k = 0; k < 200; k++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), "R2 random");
    end

    while (sb.size() != 0) @(posedge clk);
    #2;

    // Reset overrides operands mid-run.
    @(negedge clk);
    rst = 1'b1; a = 16'hFFFF; b = 16'h0001; cin = 1'b1;
    @(posedge clk);
    #1;
    check_zero("R1 midrun");
    @(negedge clk);
    rst = 1'b0;
    drive(16'h0F0F, 16'h00F1, 1'b1, "R2 after reset");
    while (sb.size() != 0) @(posedge clk);
    #2;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule